// File: doc/BRIEF.md
# I2S Serial Capture Front End

This block sits on the bit clock of an incoming I2S-style serial audio link. It watches the word-select line and the serial data line and turns the stream into 32-bit words for a downstream memory writer. The word select is low for the left channel and high for the right channel. A two-bit format input chooses one of four packings: left-only or both channels, with 32-bit or 16-bit samples. Two more inputs shift the data alignment one bit clock earlier and invert the top bit of every sample. A raw mode skips sample assembly. In raw mode the block records the line state on every bit clock as a byte and hands on four such bytes per word, so that software can decode them.

The block runs from the serial bit clock. Its output is a single-cycle valid strobe with a data word, plus a ready input from the consumer. If the consumer is not ready when a word completes, the word is lost and an overrun strobe marks the loss. While the capture enable is low the block holds no partial state and produces nothing.

Top module: `i2s_capture_fe`

## Requirements
- R1: Format 00 (left only, 32-bit) emits one word per completed left slot, holding the 32-bit sample. Right slots (word select high) produce nothing.
- R2: Format 01 (both channels, 32-bit) emits one word per completed slot, in the order the slots arrive.
- R3: Format 10 (left only, 16-bit) packs two successive left samples into one word: the earlier sample in bits 15:0 and the later one in bits 31:16.
- R4: Format 11 (both channels, 16-bit) emits one word per left/right pair: the left sample in bits 15:0 and the following right sample in bits 31:16.
- R5: With standard alignment, a word-select change sampled on a clock edge opens a new slot whose first bit is taken on the next edge. The data bit sampled on the change edge is the last bit of the slot that closes.
- R6: With early alignment, the data bit sampled on the same edge as the word-select change is the first bit of the new slot.
- R7: Bits are taken most significant first. Slot bits beyond the sample width (16 or 32) are dropped. Missing low bits are zero. In 16-bit formats each sample fills only its own half.
- R8: With sign flip enabled, the top bit of each sample (bit 31, or bit 15 of each 16-bit half) is inverted. Otherwise samples pass through unchanged.
- R9: In raw mode each bit clock forms a byte: bit 0 = word select, bit 1 = data when word select is low, bit 2 = data when word select is high (in the two-channel formats only, otherwise 0), bits 7:3 = 0. Four bytes form a word, with the first byte in bits 7:0.
- R10: While capture enable is low, no word is emitted and any partial sample, pair or raw word is discarded.
- R11: If a word is presented while ready is low, overrun is high in that cycle and the word is dropped, not retained.
- R12: After enable, slot capture starts at the first word-select change. Serial bits before it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sck | input | 1 | Serial bit clock, rising edge samples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| fmt | input | 2 | Packing format (00, 01, 10, 11 as in R1 to R4) |
| early_align | input | 1 | 1 = early data alignment |
| sign_flip | input | 1 | 1 = invert sample MSB |
| raw_mode | input | 1 | 1 = raw per-clock byte capture |
| ws | input | 1 | Word select, 0 = left, 1 = right |
| sd | input | 1 | Serial data |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 32 | Completed word |
| word_ready | input | 1 | Consumer can take the word |
| overrun | output | 1 | Word dropped because ready was low |

## Verification
The hardest situation to reach is the boundary between slots: which slot the bit sampled on the word-select change edge belongs to, combined with slots that are shorter or longer than the sample width. The bench builds every stream as a list of slots with its own channel, length and random data. It then derives the standard-alignment word select by moving the select one bit clock ahead of the early-alignment version. As a result, the same slot list drives both alignments, with lengths of 12, 16, 20, 24 and 32 bits. Random bits before the first select change probe the start-up discard.

// File: rtl/i2scap_pkg.sv
package i2scap_pkg;

  typedef enum logic [1:0] {
    FMT_MONO32   = 2'b00,
    FMT_STEREO32 = 2'b01,
    FMT_MONO16   = 2'b10,
    FMT_STEREO16 = 2'b11
  } cap_fmt_e;

endpackage

// File: rtl/i2s_slot_rx.sv
module i2s_slot_rx #(
  parameter int unsigned SAMP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              early,
  input  logic              half,
  input  logic              sign_flip,
  input  logic              ws,
  input  logic              sd,
  output logic              smp_vld,
  output logic              smp_chan,
  output logic [SAMP_W-1:0] smp_dat
);

  localparam int unsigned HALF_W = SAMP_W / 2;
  localparam int unsigned CNT_W  = $clog2(SAMP_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAMP_W);

  logic              ws_q, ws_d;
  logic              sync_q, sync_d;
  logic              chan_q, chan_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SAMP_W-1:0] acc_q, acc_d;
  logic              vld_q, vld_d;
  logic              ochan_q, ochan_d;
  logic [SAMP_W-1:0] odat_q, odat_d;

  logic              trans;
  logic [CNT_W-1:0]  msb_idx;
  logic [SAMP_W-1:0] acc_with, first_bit, flip_mask, close_dat;

  assign trans   = ws ^ ws_q;
  assign msb_idx = half ? CNT_W'(HALF_W - 1) : CNT_W'(SAMP_W - 1);

  // place the current data bit at its MSB-first position
  always_comb begin
    acc_with  = acc_q;
    first_bit = '0;
    flip_mask = '0;
    for (int i = 0; i < SAMP_W; i++) begin
      if (CNT_W'(i) <= msb_idx && (msb_idx - CNT_W'(i)) == cnt_q) acc_with[i] = sd;
      if (CNT_W'(i) == msb_idx) begin
        first_bit[i] = sd;
        flip_mask[i] = sign_flip;
      end
    end
  end

  assign close_dat = (early ? acc_q : acc_with) ^ flip_mask;

  always_comb begin
    ws_d    = ws;
    sync_d  = sync_q;
    chan_d  = chan_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    vld_d   = 1'b0;
    ochan_d = ochan_q;
    odat_d  = odat_q;
    if (!run) begin
      sync_d = 1'b0;
      cnt_d  = '0;
      acc_d  = '0;
    end else begin
      if (sync_q && trans) begin
        vld_d   = 1'b1;
        ochan_d = chan_q;
        odat_d  = close_dat;
      end
      if (trans) begin
        sync_d = 1'b1;
        chan_d = ws;
        if (early) begin
          acc_d = first_bit;
          cnt_d = CNT_W'(1);
        end else begin
          acc_d = '0;
          cnt_d = '0;
        end
      end else if (sync_q) begin
        acc_d = acc_with;
        cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q    <= 1'b0;
      sync_q  <= 1'b0;
      chan_q  <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= '0;
      vld_q   <= 1'b0;
      ochan_q <= 1'b0;
      odat_q  <= '0;
    end else begin
      ws_q    <= ws_d;
      sync_q  <= sync_d;
      chan_q  <= chan_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      vld_q   <= vld_d;
      ochan_q <= ochan_d;
      odat_q  <= odat_d;
    end
  end

  assign smp_vld  = vld_q;
  assign smp_chan = ochan_q;
  assign smp_dat  = odat_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R7
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && half && $past(half) |-> smp_dat[SAMP_W-1:HALF_W] == '0); // R7
  AST_SAMPLE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> $past(run)); // R10

endmodule

// File: rtl/i2s_word_pack.sv
module i2s_word_pack
  import i2scap_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  cap_fmt_e          fmt,
  input  logic              smp_vld,
  input  logic              smp_chan,
  input  logic [WORD_W-1:0] smp_dat,
  output logic              w_vld,
  output logic [WORD_W-1:0] w_dat
);

  localparam int unsigned HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] low_q, low_d;
  logic              have_q, have_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic              stereo, half;

  assign stereo = (fmt == FMT_STEREO32) || (fmt == FMT_STEREO16);
  assign half   = (fmt == FMT_MONO16)   || (fmt == FMT_STEREO16);

  always_comb begin
    low_d  = low_q;
    have_d = have_q;
    vld_d  = 1'b0;
    dat_d  = dat_q;
    if (!run) begin
      have_d = 1'b0;
    end else if (smp_vld) begin
      if (!half) begin
        if (stereo || !smp_chan) begin
          vld_d = 1'b1;
          dat_d = smp_dat;
        end
      end else if (!stereo) begin
        if (!smp_chan) begin
          if (have_q) begin
            vld_d  = 1'b1;
            dat_d  = {smp_dat[HALF_W-1:0], low_q};
            have_d = 1'b0;
          end else begin
            low_d  = smp_dat[HALF_W-1:0];
            have_d = 1'b1;
          end
        end
      end else begin
        if (!smp_chan) begin
          low_d  = smp_dat[HALF_W-1:0];
          have_d = 1'b1;
        end else if (have_q) begin
          vld_d  = 1'b1;
          dat_d  = {smp_dat[HALF_W-1:0], low_q};
          have_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      have_q <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      low_q  <= low_d;
      have_q <= have_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
    end
  end

  assign w_vld = vld_q;
  assign w_dat = dat_q;

  AST_MONO32_LEFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    w_vld && $past(fmt == FMT_MONO32) |-> $past(smp_vld && !smp_chan)); // R1
  AST_PAIR_CLOSED_BY_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    w_vld && $past(fmt == FMT_STEREO16) |-> $past(smp_chan)); // R4

endmodule

// File: rtl/i2s_raw_pack.sv
module i2s_raw_pack #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stereo,
  input  logic              ws,
  input  logic              sd,
  output logic              w_vld,
  output logic [WORD_W-1:0] w_dat
);

  localparam int unsigned NBYTE = WORD_W / BYTE_W;
  localparam int unsigned IDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTE - 1);

  function automatic logic [WORD_W-1:0] spare_bits();
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i % BYTE_W) >= 3;
    return m;
  endfunction
  localparam logic [WORD_W-1:0] SPARE = spare_bits();

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic [BYTE_W-1:0] byte_v;
  logic [WORD_W-1:0] word_v;

  always_comb begin
    byte_v    = '0;
    byte_v[0] = ws;
    byte_v[1] = ~ws & sd;
    byte_v[2] = stereo & ws & sd;
    word_v    = acc_q;
    word_v[int'(idx_q)*BYTE_W +: BYTE_W] = byte_v;
  end

  always_comb begin
    idx_d = idx_q;
    acc_d = acc_q;
    vld_d = 1'b0;
    dat_d = dat_q;
    if (!run) begin
      idx_d = '0;
      acc_d = '0;
    end else if (idx_q == LAST) begin
      vld_d = 1'b1;
      dat_d = word_v;
      acc_d = '0;
      idx_d = '0;
    end else begin
      acc_d = word_v;
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      idx_q <= idx_d;
      acc_q <= acc_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign w_vld = vld_q;
  assign w_dat = dat_q;

  AST_RAW_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    w_vld |-> (w_dat & SPARE) == '0); // R9

endmodule

// File: rtl/i2s_capture_fe.sv
module i2s_capture_fe
  import i2scap_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_sck,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        fmt,
  input  logic              early_align,
  input  logic              sign_flip,
  input  logic              raw_mode,
  input  logic              ws,
  input  logic              sd,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  input  logic              word_ready,
  output logic              overrun
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  cap_fmt_e          fmt_e;
  logic              slot_run, raw_run, half, stereo;
  logic              smp_vld, smp_chan;
  logic [WORD_W-1:0] smp_dat;
  logic              pk_vld, raw_vld;
  logic [WORD_W-1:0] pk_dat, raw_dat;

  always_ff @(posedge clk_sck or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign fmt_e    = cap_fmt_e'(fmt);
  assign half     = fmt[1];
  assign stereo   = fmt[0];
  assign slot_run = cap_en & ~raw_mode;
  assign raw_run  = cap_en & raw_mode;

  i2s_slot_rx #(.SAMP_W(WORD_W)) u_slot (
    .clk       (clk_sck),
    .rst_n     (rst_n_s),
    .run       (slot_run),
    .early     (early_align),
    .half      (half),
    .sign_flip (sign_flip),
    .ws        (ws),
    .sd        (sd),
    .smp_vld   (smp_vld),
    .smp_chan  (smp_chan),
    .smp_dat   (smp_dat)
  );

  i2s_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk      (clk_sck),
    .rst_n    (rst_n_s),
    .run      (slot_run),
    .fmt      (fmt_e),
    .smp_vld  (smp_vld),
    .smp_chan (smp_chan),
    .smp_dat  (smp_dat),
    .w_vld    (pk_vld),
    .w_dat    (pk_dat)
  );

  i2s_raw_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_raw (
    .clk    (clk_sck),
    .rst_n  (rst_n_s),
    .run    (raw_run),
    .stereo (stereo),
    .ws     (ws),
    .sd     (sd),
    .w_vld  (raw_vld),
    .w_dat  (raw_dat)
  );

  assign word_valid = raw_mode ? raw_vld : pk_vld;
  assign word_data  = raw_mode ? raw_dat : pk_dat;
  assign overrun    = word_valid & ~word_ready;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_sck) disable iff (!rst_n_s)
    !$past(cap_en) |-> !word_valid); // R10
  AST_RAW_LAST_WS: assert property (@(posedge clk_sck) disable iff (!rst_n_s)
    word_valid && raw_mode && $past(raw_mode) && $past(cap_en)
      |-> word_data[WORD_W-BYTE_W] == $past(ws)); // R9

endmodule

// File: tb/i2s_capture_fe_bench.sv
module i2s_capture_fe_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_en, early_align, sign_flip, raw_mode, ws, sd, word_ready;
  logic [1:0]  fmt;
  logic        word_valid, overrun;
  logic [31:0] word_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "";

  bit          sws[$];
  bit          ssd[$];
  logic [31:0] expq[$];
  logic [31:0] exp_w;

  always #10 clk = ~clk;

  i2s_capture_fe u_i2s_capture_fe (
    .clk_sck     (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .fmt         (fmt),
    .early_align (early_align),
    .sign_flip   (sign_flip),
    .raw_mode    (raw_mode),
    .ws          (ws),
    .sd          (sd),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .word_ready  (word_ready),
    .overrun     (overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference comparison on every clock, 5 ns after the rising edge
  always @(posedge clk) begin
    #5;
    if (!done && word_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected word"}, word_data, 32'h0);
      end else begin
        exp_w = expq.pop_front();
        if (word_ready) chk(word_data == exp_w && !overrun, cur_req, word_data, exp_w);
        else            chk(overrun == 1'b1, "R11 overrun on drop", {31'b0, overrun}, 32'h1);
      end
    end
  end

  // slot stream and expected words, from the requirements
  task automatic build_slots(input logic [1:0] f, input bit early, input bit flip,
                             input int nfr, input int len, input bit noisy);
    int          chans[$];
    logic [31:0] samps[$];
    bit          wse[$];
    int          w;
    logic [31:0] d, s;
    logic [15:0] low;
    bit          have;
    sws.delete(); ssd.delete(); expq.delete();
    for (int i = 0; i < 3; i++) begin
      wse.push_back(1'b1);
      ssd.push_back(noisy ? 1'($urandom) : 1'b0);
    end
    w = f[1] ? 16 : 32;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int ch = 0; ch < 2; ch++) begin
        d = $urandom;
        for (int b = len - 1; b >= 0; b--) begin
          wse.push_back(ch[0]);
          ssd.push_back(d[b]);
        end
        s = '0;
        for (int i = 0; i < w; i++) if (i < len) s[w-1-i] = d[len-1-i];
        if (flip) s[w-1] = ~s[w-1];
        chans.push_back(ch);
        samps.push_back(s);
      end
    end
    for (int i = 0; i < 3; i++) begin
      wse.push_back(1'b0);
      ssd.push_back(1'b0);
    end
    for (int i = 0; i < wse.size(); i++) begin
      if (!early && i < wse.size() - 1) sws.push_back(wse[i+1]);
      else                              sws.push_back(wse[i]);
    end
    have = 1'b0;
    low  = '0;
    for (int k = 0; k < samps.size(); k++) begin
      case (f)
        2'b00: if (chans[k] == 0) expq.push_back(samps[k]);
        2'b01: expq.push_back(samps[k]);
        2'b10: if (chans[k] == 0) begin
                 if (have) begin expq.push_back({samps[k][15:0], low}); have = 1'b0; end
                 else begin low = samps[k][15:0]; have = 1'b1; end
               end
        default: if (chans[k] == 0) begin low = samps[k][15:0]; have = 1'b1; end
                 else if (have) begin expq.push_back({samps[k][15:0], low}); have = 1'b0; end
      endcase
    end
  endtask

  task automatic build_raw(input bit st, input int ncyc);
    logic [31:0] wd;
    logic [7:0]  by;
    sws.delete(); ssd.delete(); expq.delete();
    wd = '0;
    for (int i = 0; i < ncyc; i++) begin
      bit a, b;
      a = 1'($urandom);
      b = 1'($urandom);
      sws.push_back(a);
      ssd.push_back(b);
      by = {5'b0, st & a & b, ~a & b, a};
      wd[8*(i%4) +: 8] = by;
      if (i % 4 == 3) begin expq.push_back(wd); wd = '0; end
    end
  endtask

  task automatic run_stream(input bit en);
    @(negedge clk);
    cap_en = en;
    for (int i = 0; i < sws.size(); i++) begin
      if (i > 0) @(negedge clk);
      ws = sws[i];
      sd = ssd[i];
    end
    repeat (3) @(negedge clk);
    @(negedge clk);
    cap_en = 1'b0;
    ws = 1'b1;
    sd = 1'b0;
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, {cur_req, " all expected words seen"}, expq.size(), 32'h0);
  endtask

  task automatic setup(input logic [1:0] f, input bit e, input bit fl, input bit rw, input string req);
    @(negedge clk);
    fmt = f; early_align = e; sign_flip = fl; raw_mode = rw; cur_req = req;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_en = 1'b0; fmt = 2'b00; early_align = 1'b0; sign_flip = 1'b0;
    raw_mode = 1'b0; ws = 1'b1; sd = 1'b0; word_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b0 && overrun == 1'b0, "R10 reset state", {word_valid, overrun}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(word_valid == 1'b0 && overrun == 1'b0, "R10 after reset", {word_valid, overrun}, 32'h0);

    setup(2'b00, 1'b0, 1'b0, 1'b0, "R1 R5 R7 mono32 std");
    build_slots(2'b00, 1'b0, 1'b0, 3, 32, 1'b0); run_stream(1'b1);
    setup(2'b01, 1'b0, 1'b0, 1'b0, "R2 R7 R12 stereo32 std zero-fill");
    build_slots(2'b01, 1'b0, 1'b0, 3, 24, 1'b1); run_stream(1'b1);
    setup(2'b10, 1'b1, 1'b1, 1'b0, "R3 R6 R8 mono16 early truncate");
    build_slots(2'b10, 1'b1, 1'b1, 4, 20, 1'b0); run_stream(1'b1);
    setup(2'b11, 1'b0, 1'b1, 1'b0, "R4 R8 stereo16 std");
    build_slots(2'b11, 1'b0, 1'b1, 3, 16, 1'b0); run_stream(1'b1);
    setup(2'b01, 1'b1, 1'b1, 1'b0, "R2 R6 R8 R12 stereo32 early");
    build_slots(2'b01, 1'b1, 1'b1, 3, 32, 1'b1); run_stream(1'b1);
    setup(2'b00, 1'b1, 1'b0, 1'b0, "R1 R6 R7 mono32 early short slot");
    build_slots(2'b00, 1'b1, 1'b0, 3, 12, 1'b0); run_stream(1'b1);
    setup(2'b01, 1'b0, 1'b0, 1'b1, "R9 raw stereo");
    build_raw(1'b1, 24); run_stream(1'b1);
    setup(2'b00, 1'b0, 1'b0, 1'b1, "R9 raw mono");
    build_raw(1'b0, 16); run_stream(1'b1);
    setup(2'b01, 1'b0, 1'b0, 1'b0, "R10 capture disabled");
    build_slots(2'b01, 1'b0, 1'b0, 3, 32, 1'b0); expq.delete(); run_stream(1'b0);
    setup(2'b00, 1'b0, 1'b0, 1'b0, "R11 ready low");
    word_ready = 1'b0;
    build_slots(2'b00, 1'b0, 1'b0, 3, 32, 1'b0); run_stream(1'b1);
    word_ready = 1'b1;
    setup(2'b11, 1'b1, 1'b0, 1'b0, "R4 R11 stereo16 early after drops");
    build_slots(2'b11, 1'b1, 1'b0, 3, 16, 1'b0); run_stream(1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule